// File: doc/BRIEF.md
# Multi-Stage Trigger Sequencer

This block watches a stream of wide input samples and decides when a capture should begin. It holds a small bank of trigger stages. Each stage has a mask word, a value word and a start flag, and all of them are written through one configuration write port. A stage matches a sample when every sample bit selected by its mask equals the same bit of its value word. The stages are walked in order. Only the stage the sequencer currently points at is compared, and a match on a stage without the start flag moves the pointer on to the next stage. A match on a stage that has the start flag produces a one-cycle trigger pulse.

After the trigger the block counts the samples still to be stored. The capture-size word carries a read count and a delay count, each stored as the count minus one and each in units of four samples. On the trigger, the countdown loads the delay count times four. When the last post-trigger sample has been accepted, a one-cycle done pulse tells the sample memory to stop writing. The block also reports the pre-trigger portion, which is the read count minus the delay count.

The controller has three states. IDLE waits for a run command. ARMED compares samples against the current stage. DELAY counts post-trigger samples. The transitions are:
- IDLE→ARMED on run.
- ARMED→ARMED on run, which restarts at stage 0.
- ARMED→DELAY on a match of a start-flagged stage.
- DELAY→IDLE when the last post-trigger sample is accepted.
- DELAY→ARMED on run.

Top module: `trig_seq_unit`

## Requirements
- R1: After reset, `armed`, `trig_pulse` and `done_pulse` are 0, `post_left` is 0 and `stage_idx` is 0. Stage 0 has a zero mask and its start flag set, and every other stage has a zero mask and a clear start flag. The default capture-size word is 0.
- R2: A stage matches a sample when `((smp_data ^ value) & mask) == 0`. Bits with a mask bit of 0 are don't-care.
- R3: In ARMED, only the stage at `stage_idx` is compared. A matching stage whose start flag is clear advances `stage_idx` by one on the next clock.
- R4: Bit 3 of a stage's configuration word is its start flag. A match on a stage with the start flag set gives `trig_pulse` = 1 for exactly one cycle, on the clock after the matching sample, and the state moves to DELAY.
- R5: A `run` pulse in any state gives `armed` = 1, `stage_idx` = 0 and `post_left` = 0 on the next clock. This aborts any countdown in progress.
- R6: The capture-size word holds (read count − 1) in bits 31:16 and (delay count − 1) in bits 15:0. On the trigger, `post_left` loads (bits 15:0 + 1) × 4. `pre_groups` equals bits 31:16 minus bits 15:0, or 0 when that difference would be negative.
- R7: In DELAY, each accepted sample lowers `post_left` by one. The sample that brings it from 1 to 0 gives `done_pulse` = 1 for one cycle on the next clock, and the state returns to IDLE.
- R8: A clock with `smp_valid` = 0 neither compares nor counts. `stage_idx` and `post_left` hold their values.
- R9: Configuration writes use `cfg_sel[3:2]` as the stage number and `cfg_sel[1:0]` as the field: 0 = mask, 1 = value, 2 = configuration, 3 = capture-size word. For field 3 the stage bits are ignored. A write takes effect for samples from the next clock on.
- R10: `trig_pulse` occurs at most once between two `run` commands.
- R11: A match on the last stage without a start flag leaves `stage_idx` at the last stage and produces no trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Stage number (3:2) and field (1:0) |
| cfg_data | input | 32 | Configuration write data |
| run | input | 1 | Arm command, restarts at stage 0 |
| smp_valid | input | 1 | Sample qualifier |
| smp_data | input | 32 | Input sample |
| armed | output | 1 | Sequencer is comparing stages |
| stage_idx | output | 2 | Stage currently compared |
| trig_pulse | output | 1 | Capture-start event |
| post_left | output | 19 | Post-trigger samples still to store |
| pre_groups | output | 16 | Pre-trigger portion in four-sample groups |
| done_pulse | output | 1 | Last post-trigger sample accepted |

## Verification
The sequencer is driven with several kinds of input:
- A default run with no stage programmed, which shows that the capture starts on the first valid sample.
- A three-stage cascade fed out of order. Samples that match a later stage before an earlier one show whether the compare is restricted to the current stage.
- Samples with the qualifier low inside the cascade and inside the countdown, which separate accepted samples from ignored ones.
- A run command mid-countdown, a cascade that ends on a stage with no start flag, and long stretches of random samples against random masks. The random stretches tell a correct masked compare apart from one that uses the wrong polarity or ignores the mask.

// File: rtl/trig_pkg.sv
package trig_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_DELAY = 2'd2
    } trig_state_e;

    typedef enum logic [1:0] {
        FLD_MASK   = 2'd0,
        FLD_VALUE  = 2'd1,
        FLD_CONFIG = 2'd2,
        FLD_SIZE   = 2'd3
    } cfg_field_e;

    // position of the start flag inside a stage configuration word
    localparam int START_BIT = 3;

endpackage

// File: rtl/trig_stage_bank.sv
module trig_stage_bank
    import trig_pkg::*;
#(
    parameter int NSTG = 4,
    parameter int DW   = 32,
    parameter int SELW = (NSTG > 1) ? $clog2(NSTG) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [SELW-1:0] wr_stage,
    input  logic [1:0]      wr_field,
    input  logic [DW-1:0]   wr_data,
    input  logic [DW-1:0]   smp_data,
    output logic [NSTG-1:0] hit,
    output logic [NSTG-1:0] is_start
);

    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        logic [DW-1:0] mask_q;
        logic [DW-1:0] value_q;
        logic          start_q;
        logic          sel_me;

        assign sel_me = wr_en && (wr_stage == SELW'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q  <= '0;
                value_q <= '0;
                start_q <= (g == 0);
            end else if (sel_me) begin
                unique case (cfg_field_e'(wr_field))
                    FLD_MASK:   mask_q  <= wr_data;
                    FLD_VALUE:  value_q <= wr_data;
                    FLD_CONFIG: start_q <= wr_data[START_BIT];
                    FLD_SIZE:   ;
                    default:    ;
                endcase
            end
        end

        assign hit[g]      = (((smp_data ^ value_q) & mask_q) == '0);
        assign is_start[g] = start_q;
    end

endmodule

// File: rtl/trig_seq_ctrl.sv
module trig_seq_ctrl
    import trig_pkg::*;
#(
    parameter int NSTG = 4,
    parameter int CW   = 16,
    parameter int SELW = (NSTG > 1) ? $clog2(NSTG) : 1,
    parameter int RW   = CW + 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            smp_valid,
    input  logic [NSTG-1:0] hit,
    input  logic [NSTG-1:0] is_start,
    input  logic [CW-1:0]   dly_field,
    output logic            armed,
    output logic [SELW-1:0] stage_idx,
    output logic            trig_pulse,
    output logic            done_pulse,
    output logic [RW-1:0]   post_left
);

    localparam logic [SELW-1:0] LAST = SELW'(NSTG - 1);

    trig_state_e    state, nxt;
    logic [SELW-1:0] ptr;
    logic [RW-1:0]   left_q;
    logic [RW-1:0]   load_val;
    logic            cur_hit, cur_start, fire, last_smp;

    assign load_val  = (RW'(dly_field) + RW'(1)) << 2;
    assign cur_hit   = smp_valid && hit[ptr];
    assign cur_start = is_start[ptr];
    assign fire      = cur_hit && cur_start;
    assign last_smp  = smp_valid && (left_q == RW'(1));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (run) nxt = ST_ARMED;
            ST_ARMED: if (run) nxt = ST_ARMED;
                      else if (fire) nxt = ST_DELAY;
            ST_DELAY: if (run) nxt = ST_ARMED;
                      else if (last_smp) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs, stage pointer and countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr        <= '0;
            left_q     <= '0;
            trig_pulse <= 1'b0;
            done_pulse <= 1'b0;
        end else begin
            trig_pulse <= 1'b0;
            done_pulse <= 1'b0;
            if (run) begin
                ptr    <= '0;
                left_q <= '0;
            end else begin
                unique case (state)
                    ST_ARMED: begin
                        if (fire) begin
                            trig_pulse <= 1'b1;
                            left_q     <= load_val;
                        end else if (cur_hit && ptr != LAST) begin
                            ptr <= ptr + 1'b1;
                        end
                    end
                    ST_DELAY: begin
                        if (smp_valid) begin
                            left_q <= left_q - 1'b1;
                            if (left_q == RW'(1)) done_pulse <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign armed     = (state == ST_ARMED);
    assign stage_idx = ptr;
    assign post_left = left_q;

    // R4: the capture-start event lasts one cycle
    a_r4_trig_single: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |=> !trig_pulse);

    // R6: countdown starts at the programmed delay in samples
    a_r6_load_delay: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> (post_left == ((RW'($past(dly_field)) + RW'(1)) << 2)));

    // R7: done only after the countdown empties, back in idle
    a_r7_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (post_left == '0 && state == ST_IDLE));

    // R8: qualifier low freezes the countdown
    a_r8_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DELAY && !smp_valid && !run) |=> $stable(post_left));

    // R5: run rearms at stage 0
    a_r5_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (armed && stage_idx == '0 && post_left == '0));

    // R3: the pointer moves by at most one stage per clock
    a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && !run) |=>
            (ptr == $past(ptr) || ptr == $past(ptr) + 1'b1));

endmodule

// File: rtl/trig_seq_unit.sv
module trig_seq_unit
    import trig_pkg::*;
#(
    parameter int NSTG = 4,
    parameter int DW   = 32,
    parameter int CW   = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [((NSTG > 1) ? $clog2(NSTG) : 1)+1:0] cfg_sel,
    input  logic [DW-1:0]         cfg_data,
    input  logic                  run,
    input  logic                  smp_valid,
    input  logic [DW-1:0]         smp_data,
    output logic                  armed,
    output logic [((NSTG > 1) ? $clog2(NSTG) : 1)-1:0] stage_idx,
    output logic                  trig_pulse,
    output logic [CW+2:0]         post_left,
    output logic [CW-1:0]         pre_groups,
    output logic                  done_pulse
);

    localparam int SELW = (NSTG > 1) ? $clog2(NSTG) : 1;
    localparam int AW   = SELW + 2;
    localparam int RW   = CW + 3;

    logic [NSTG-1:0] hit, is_start;
    logic [CW-1:0]   rd_f, dl_f;
    logic            size_we;

    assign size_we = cfg_we && (cfg_field_e'(cfg_sel[1:0]) == FLD_SIZE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_f <= '0;
            dl_f <= '0;
        end else if (size_we) begin
            rd_f <= cfg_data[2*CW-1:CW];
            dl_f <= cfg_data[CW-1:0];
        end
    end

    assign pre_groups = (rd_f >= dl_f) ? (rd_f - dl_f) : '0;

    trig_stage_bank #(.NSTG(NSTG), .DW(DW), .SELW(SELW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we && !size_we),
        .wr_stage (cfg_sel[AW-1:2]),
        .wr_field (cfg_sel[1:0]),
        .wr_data  (cfg_data),
        .smp_data (smp_data),
        .hit      (hit),
        .is_start (is_start)
    );

    trig_seq_ctrl #(.NSTG(NSTG), .CW(CW), .SELW(SELW), .RW(RW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .smp_valid  (smp_valid),
        .hit        (hit),
        .is_start   (is_start),
        .dly_field  (dl_f),
        .armed      (armed),
        .stage_idx  (stage_idx),
        .trig_pulse (trig_pulse),
        .done_pulse (done_pulse),
        .post_left  (post_left)
    );

    // R6: pre-trigger portion never exceeds the read count
    a_r6_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pre_groups <= rd_f);

endmodule

// File: tb/sim_trig_seq_unit.sv
module sim_trig_seq_unit;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [31:0] cfg_data = '0;
    logic        run = 1'b0;
    logic        smp_valid = 1'b0;
    logic [31:0] smp_data = '0;
    logic        armed, trig_pulse, done_pulse;
    logic [1:0]  stage_idx;
    logic [18:0] post_left;
    logic [15:0] pre_groups;

    always #2.5 clk = ~clk;

    trig_seq_unit u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .run(run), .smp_valid(smp_valid),
        .smp_data(smp_data), .armed(armed), .stage_idx(stage_idx),
        .trig_pulse(trig_pulse), .post_left(post_left),
        .pre_groups(pre_groups), .done_pulse(done_pulse)
    );

    int    checks = 0;
    int    errors = 0;
    int    n_trig = 0;
    int    n_done = 0;
    string cur_req = "R1";
    bit    finished = 1'b0;

    // behavioural reference model: 0 idle, 1 armed, 2 counting
    int          m_st, m_ptr, m_left, m_rd, m_dl;
    bit          m_trig, m_done;
    logic [31:0] m_mask [4];
    logic [31:0] m_val  [4];
    bit          m_start[4];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_ptr = 0; m_left = 0; m_rd = 0; m_dl = 0;
            m_trig = 0; m_done = 0;
            for (int i = 0; i < 4; i++) begin
                m_mask[i] = '0; m_val[i] = '0; m_start[i] = (i == 0);
            end
        end else begin
            m_trig = 0; m_done = 0;
            if (run) begin
                m_st = 1; m_ptr = 0; m_left = 0;
            end else if (m_st == 1) begin
                if (smp_valid && ((smp_data ^ m_val[m_ptr]) & m_mask[m_ptr]) == 0) begin
                    if (m_start[m_ptr]) begin
                        m_trig = 1; m_st = 2; m_left = (m_dl + 1) * 4;
                    end else if (m_ptr < 3) begin
                        m_ptr++;
                    end
                end
            end else if (m_st == 2) begin
                if (smp_valid) begin
                    if (m_left == 1) begin
                        m_done = 1; m_st = 0; m_left = 0;
                    end else begin
                        m_left--;
                    end
                end
            end
            if (cfg_we) begin
                case (cfg_sel[1:0])
                    2'd0: m_mask[cfg_sel[3:2]] = cfg_data;
                    2'd1: m_val[cfg_sel[3:2]] = cfg_data;
                    2'd2: m_start[cfg_sel[3:2]] = cfg_data[3];
                    default: begin m_rd = cfg_data[31:16]; m_dl = cfg_data[15:0]; end
                endcase
            end
        end
    end

    task automatic chk(input string nm, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, nm, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("armed", armed, (m_st == 1));
        chk("trig_pulse", trig_pulse, m_trig);
        chk("done_pulse", done_pulse, m_done);
        chk("post_left", post_left, m_left);
        chk("stage_idx", stage_idx, m_ptr);
        chk("pre_groups", pre_groups, (m_rd >= m_dl) ? (m_rd - m_dl) : 0);
        if (trig_pulse === 1'b1) n_trig++;
        if (done_pulse === 1'b1) n_done++;
    endtask

    task automatic cyc();
        @(negedge clk);
        compare_all();
    endtask

    task automatic drive(input bit we, input logic [3:0] sel, input logic [31:0] d,
                         input bit r, input bit v, input logic [31:0] s);
        cfg_we = we; cfg_sel = sel; cfg_data = d; run = r;
        smp_valid = v; smp_data = s;
        cyc();
        cfg_we = 0; run = 0; smp_valid = 0;
    endtask

    task automatic wr(input int stg, input int fld, input logic [31:0] d);
        drive(1, 4'((stg << 2) | fld), d, 0, 0, '0);
    endtask

    task automatic go();
        drive(0, '0, '0, 1, 0, '0);
    endtask

    task automatic smp(input bit v, input logic [31:0] s);
        drive(0, '0, '0, 0, v, s);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) smp(0, '0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            finished = 1'b1;
            $finish;
        end
    end

    initial begin
        // R1: reset state and default immediate start
        cur_req = "R1";
        repeat (3) cyc();
        rst_n = 1'b1;
        idle(3);
        go();
        smp(1, 32'hDEAD_BEEF);
        chk("R1 trig count", n_trig, 1);
        for (int i = 0; i < 4; i++) smp(1, 32'(i));
        chk("R1 done count", n_done, 1);
        idle(2);

        // R9 and R6: capture size and field addressing
        cur_req = "R9";
        wr(3, 3, {16'd9, 16'd2});
        cur_req = "R6";
        idle(1);
        chk("R6 pre_groups", pre_groups, 7);

        // program three-stage cascade
        cur_req = "R9";
        wr(0, 0, 32'h0000_00FF); wr(0, 1, 32'h0000_005A); wr(0, 2, 32'h0);
        wr(1, 0, 32'hFF00_0000); wr(1, 1, 32'h8100_0000); wr(1, 2, 32'h0);
        wr(2, 0, 32'h0000_000F); wr(2, 1, 32'h0000_0003); wr(2, 2, 32'h8);

        // R3: only current stage compared
        cur_req = "R3";
        n_trig = 0; n_done = 0;
        go();
        smp(1, 32'h8100_0000);      // stage 1 pattern, stage 0 not yet matched
        smp(1, 32'h1234_5603);      // stage 2 pattern only
        chk("R3 still stage0", stage_idx, 0);
        cur_req = "R2";
        smp(1, 32'hABCD_EF5A);      // stage 0: only low byte compared
        chk("R2 advance to 1", stage_idx, 1);
        cur_req = "R3";
        smp(1, 32'h0000_0003);      // stage 2 pattern while at stage 1
        smp(1, 32'h81FF_FFF0);
        chk("R3 at stage 2", stage_idx, 2);
        cur_req = "R8";
        smp(0, 32'h0000_0003);      // qualifier low: ignored
        chk("R8 no trig", n_trig, 0);
        cur_req = "R4";
        smp(1, 32'hFFFF_FFF3);
        chk("R4 trig", n_trig, 1);
        chk("R6 load", post_left, 12);
        cur_req = "R7";
        for (int i = 0; i < 11; i++) begin
            smp(1, 32'(i));
            smp(0, '0);
        end
        chk("R7 not yet done", n_done, 0);
        smp(1, 32'h0);
        chk("R7 done", n_done, 1);
        cur_req = "R10";
        smp(1, 32'hFFFF_FFF3);
        idle(2);
        chk("R10 single trig", n_trig, 1);

        // R5: run aborts countdown
        cur_req = "R5";
        go();
        smp(1, 32'h5A); smp(1, 32'h8100_0000); smp(1, 32'h3);
        smp(1, 32'h0); smp(1, 32'h0);
        go();
        chk("R5 rearm left", post_left, 0);
        chk("R5 rearm idx", stage_idx, 0);
        idle(2);

        // R11: cascade ending on a stage without start flag
        cur_req = "R11";
        wr(2, 2, 32'h0); wr(3, 0, 32'h0); wr(3, 2, 32'h0);
        n_trig = 0;
        go();
        smp(1, 32'h5A); smp(1, 32'h8100_0000); smp(1, 32'h3);
        smp(1, 32'h0); smp(1, 32'h0); smp(1, 32'h0);
        chk("R11 idx saturates", stage_idx, 3);
        chk("R11 no trig", n_trig, 0);

        // R6: delay larger than read count
        cur_req = "R6";
        wr(0, 3, {16'd1, 16'd5});
        idle(1);
        chk("R6 pre clamp", pre_groups, 0);

        // R2: random masks and samples on a single start stage
        cur_req = "R2";
        wr(0, 2, 32'h8);
        wr(0, 3, {16'd3, 16'd0});
        for (int k = 0; k < 60; k++) begin
            logic [31:0] mk, vl;
            mk = $urandom & $urandom;
            vl = $urandom;
            wr(0, 0, mk); wr(0, 1, vl);
            go();
            for (int j = 0; j < 12; j++) begin
                if (($urandom % 5) == 0) smp(1, (vl & mk) | ($urandom & ~mk));
                else smp($urandom % 2, $urandom);
            end
            idle(1);
        end

        cur_req = "R7";
        idle(3);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule